// File: doc/BRIEF.md
# Wide-Write Narrow-Read Dual-Port RAM

This block is a synchronous simple dual-port memory. Its write port is wider than its read port. A single write stores a word that is `2^SHIFT` lanes wide. The read port then returns that word one `LANE_W`-bit lane per address. Each port has its own clock. The write side sees the memory as `2^(ADDR_W-SHIFT)` wide rows. The read side sees the same storage as `2^ADDR_W` narrow words.

A typical use is a producer that emits whole words in bursts, paired with a consumer that walks the same data a lane at a time. The lane order follows big-endian packing: the most significant lane of the wide word sits at the lowest narrow address of its group. Read data is registered. A read-side synchronous reset clears only the output register and never touches the stored contents.

Top module: `lane_split_ram`

## Requirements
- R1: The write data port is `LANE_W << SHIFT` bits wide and the write address is `ADDR_W - SHIFT` bits wide; the read address is `ADDR_W` bits and the read data `LANE_W` bits.
- R2: A write with `wr_en` high at wide address A, taken on a rising `wr_clk` edge, stores all `2^SHIFT` lanes, making narrow addresses `A*2^SHIFT` up to `A*2^SHIFT + 2^SHIFT - 1` readable.
- R3: Lane ordering: narrow address `A*2^SHIFT + k` holds bits `[(2^SHIFT-1-k)*LANE_W +: LANE_W]` of the wide word, so lane 0 (lowest address) holds the most significant slice.
- R4: With `wr_en` low, a rising `wr_clk` edge leaves every stored location unchanged, whatever `wr_addr` and `wr_data` carry.
- R5: When the same rising edge both writes a row and reads a narrow address inside it, the read returns the contents from before that write.
- R6: While `rd_rst_n` is low, each rising `rd_clk` edge forces `rd_data` to zero. The stored contents survive the reset.
- R7: `rd_data` changes only on a rising `rd_clk` edge and shows the word at the `rd_addr` sampled on that edge (one cycle of latency).
- R8: Writing a row again replaces all of its lanes and leaves the neighbouring rows, including those at address 0 and at the top address, untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_en | input | 1 | Write strobe for a whole wide row |
| wr_addr | input | ADDR_W-SHIFT | Wide row address |
| wr_data | input | LANE_W<<SHIFT | Wide write word, most significant lane first |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Active-low synchronous clear of the read output register |
| rd_addr | input | ADDR_W | Narrow read address |
| rd_data | output | LANE_W | Registered narrow read data |

## Verification
The hardest case to reach from the ports is a read and a write landing on the same row at the same clock edge. Only that collision separates old-data behaviour from write-through behaviour. The bench runs both ports from one clock and drives a row write and a read of one of its lanes in the same half cycle. It then samples the output right after that edge, expecting the old lane. A follow-up read confirms that the new word did land. A second case that is hard to observe is reset leaving the contents intact. It is covered by reading back an earlier word after a reset taken in the middle of the run.

// File: rtl/lane_split_pkg.sv
package lane_split_pkg;

  // Number of read lanes packed into one wide word.
  function automatic int unsigned lane_count(input int unsigned shift);
    return 32'd1 << shift;
  endfunction

  // LSB position of lane k inside the wide word; lane 0 is the top slice.
  function automatic int unsigned lane_lsb(input int unsigned lane,
                                           input int unsigned lanes,
                                           input int unsigned lane_w);
    return (lanes - 1 - lane) * lane_w;
  endfunction

  // Narrow address of lane k of wide row r.
  function automatic int unsigned narrow_addr(input int unsigned row,
                                              input int unsigned lane,
                                              input int unsigned shift);
    return (row << shift) + lane;
  endfunction

endpackage

// File: rtl/lane_split_wr_fanout.sv
module lane_split_wr_fanout
  import lane_split_pkg::*;
#(
  parameter int unsigned LANE_W  = 8,
  parameter int unsigned SHIFT   = 2,
  parameter int unsigned WADDR_W = 8,
  localparam int unsigned LANES  = lane_count(SHIFT),
  localparam int unsigned WIDE_W = LANE_W * LANES
) (
  input  logic                          wr_en,
  input  logic [WADDR_W-1:0]            wr_addr,
  input  logic [WIDE_W-1:0]             wr_data,
  output logic [LANES-1:0]              lane_we,
  output logic [WADDR_W-1:0]            lane_row,
  output logic [LANES-1:0][LANE_W-1:0]  lane_din
);

  assign lane_row = wr_addr;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int unsigned LSB = lane_lsb(k, LANES, LANE_W);
    assign lane_we[k]  = wr_en;
    assign lane_din[k] = wr_data[LSB +: LANE_W];
  end

endmodule

// File: rtl/lane_split_bank.sv
module lane_split_bank #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned ROW_W  = 8,
  localparam int unsigned ROWS  = 1 << ROW_W
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [ROW_W-1:0]  waddr,
  input  logic [LANE_W-1:0] wdata,
  input  logic              rd_clk,
  input  logic [ROW_W-1:0]  raddr,
  output logic [LANE_W-1:0] rdata
);

  logic [LANE_W-1:0] mem [ROWS];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/lane_split_rd_select.sv
module lane_split_rd_select #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned SHIFT  = 2,
  localparam int unsigned LANES = 1 << SHIFT
) (
  input  logic                          rd_clk,
  input  logic                          rd_rst_n,
  input  logic [SHIFT-1:0]              lane_sel,
  input  logic [LANES-1:0][LANE_W-1:0]  bank_q,
  output logic [SHIFT-1:0]              lane_q,
  output logic                          out_valid,
  output logic [LANE_W-1:0]             rd_data
);

  always_ff @(posedge rd_clk) begin
    if (!rd_rst_n) begin
      lane_q    <= '0;
      out_valid <= 1'b0;
    end else begin
      lane_q    <= lane_sel;
      out_valid <= 1'b1;
    end
  end

  assign rd_data = out_valid ? bank_q[lane_q] : '0;

endmodule

// File: rtl/lane_split_ram.sv
module lane_split_ram
  import lane_split_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned SHIFT  = 2,
  localparam int unsigned LANES   = lane_count(SHIFT),
  localparam int unsigned WIDE_W  = LANE_W * LANES,
  localparam int unsigned WADDR_W = ADDR_W - SHIFT
) (
  input  logic               wr_clk,
  input  logic               wr_en,
  input  logic [WADDR_W-1:0] wr_addr,
  input  logic [WIDE_W-1:0]  wr_data,
  input  logic               rd_clk,
  input  logic               rd_rst_n,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [LANE_W-1:0]  rd_data
);

  // Named internal events, brought out for the checker.
  logic [LANES-1:0]             lane_we;
  logic [WADDR_W-1:0]           lane_row;
  logic [LANES-1:0][LANE_W-1:0] lane_din;
  logic [LANES-1:0][LANE_W-1:0] bank_q;
  logic [SHIFT-1:0]             lane_q;
  logic                         out_valid;

  // Narrow address splits into row (upper bits) and lane (lower bits).
  logic [WADDR_W-1:0] rd_row;
  logic [SHIFT-1:0]   rd_lane;
  assign rd_row  = rd_addr[ADDR_W-1:SHIFT];
  assign rd_lane = rd_addr[SHIFT-1:0];

  lane_split_wr_fanout #(
    .LANE_W (LANE_W),
    .SHIFT  (SHIFT),
    .WADDR_W(WADDR_W)
  ) u_fanout (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .lane_we (lane_we),
    .lane_row(lane_row),
    .lane_din(lane_din)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_bank
    lane_split_bank #(
      .LANE_W(LANE_W),
      .ROW_W (WADDR_W)
    ) u_bank (
      .wr_clk(wr_clk),
      .we    (lane_we[k]),
      .waddr (lane_row),
      .wdata (lane_din[k]),
      .rd_clk(rd_clk),
      .raddr (rd_row),
      .rdata (bank_q[k])
    );
  end

  lane_split_rd_select #(
    .LANE_W(LANE_W),
    .SHIFT (SHIFT)
  ) u_select (
    .rd_clk   (rd_clk),
    .rd_rst_n (rd_rst_n),
    .lane_sel (rd_lane),
    .bank_q   (bank_q),
    .lane_q   (lane_q),
    .out_valid(out_valid),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/lane_split_ram_chk.sv
module lane_split_ram_chk #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned SHIFT  = 2,
  localparam int unsigned LANES = 1 << SHIFT
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rd_rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [LANE_W-1:0] rd_data,
  input logic [LANES-1:0]  lane_we,
  input logic [SHIFT-1:0]  lane_q
);

  logic warm = 1'b0;
  always_ff @(posedge rd_clk) warm <= 1'b1;

  // R2: a write strobe reaches every lane bank
  p_all_lanes_r2: assert property (@(posedge wr_clk) disable iff (!rd_rst_n)
    wr_en |-> (&lane_we));

  // R4: no bank is written while the strobe is low
  p_idle_no_write_r4: assert property (@(posedge wr_clk) disable iff (!rd_rst_n)
    !wr_en |-> (lane_we == '0));

  // R6: the first edge out of reset still shows the cleared output
  p_reset_clear_r6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (warm && $past(!rd_rst_n)) |-> (rd_data == '0));

  // R7: lane select is the low address bits from one edge earlier
  p_lane_sel_r7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (warm && $past(rd_rst_n)) |-> (lane_q == $past(rd_addr[SHIFT-1:0])));

endmodule

bind lane_split_ram lane_split_ram_chk #(
  .ADDR_W(ADDR_W),
  .LANE_W(LANE_W),
  .SHIFT (SHIFT)
) u_chk (
  .wr_clk  (wr_clk),
  .rd_clk  (rd_clk),
  .rd_rst_n(rd_rst_n),
  .wr_en   (wr_en),
  .rd_addr (rd_addr),
  .rd_data (rd_data),
  .lane_we (lane_we),
  .lane_q  (lane_q)
);

// File: tb/lane_split_ram_test.sv
`timescale 1ns/1ps
module lane_split_ram_test;
  localparam int ADDR_W = 10;
  localparam int LANE_W = 8;
  localparam int SHIFT  = 2;
  localparam int WADDR_W = ADDR_W - SHIFT;
  localparam int WIDE_W  = LANE_W * 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               wr_en = 1'b0;
  logic [WADDR_W-1:0] wr_addr = '0;
  logic [WIDE_W-1:0]  wr_data = '0;
  logic               rd_rst_n = 1'b0;
  logic [ADDR_W-1:0]  rd_addr = '0;
  logic [LANE_W-1:0]  rd_data;

  lane_split_ram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .SHIFT(SHIFT)) uut (
    .wr_clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_clk(clk), .rd_rst_n(rd_rst_n), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // {is_write, address, data-or-expected}
  localparam int NV = 15;
  localparam logic [42:0] VECS [NV] = '{
    {1'b1, 10'h021, 32'hdeadbeef},
    {1'b0, 10'h084, 32'h000000de},
    {1'b0, 10'h085, 32'h000000ad},
    {1'b0, 10'h086, 32'h000000be},
    {1'b0, 10'h087, 32'h000000ef},
    {1'b1, 10'h000, 32'h01234567},
    {1'b0, 10'h000, 32'h00000001},
    {1'b0, 10'h003, 32'h00000067},
    {1'b1, 10'h0ff, 32'hcafef00d},
    {1'b0, 10'h3fc, 32'h000000ca},
    {1'b0, 10'h3fd, 32'h000000fe},
    {1'b0, 10'h3ff, 32'h0000000d},
    {1'b1, 10'h021, 32'h11223344},
    {1'b0, 10'h085, 32'h00000022},
    {1'b0, 10'h003, 32'h00000067}
  };

  task automatic check(input logic [LANE_W-1:0] act, input logic [LANE_W-1:0] exp,
                       input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic en, input logic [WADDR_W-1:0] a,
                          input logic [WIDE_W-1:0] d);
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, input logic [LANE_W-1:0] exp,
                         input string req);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    check(rd_data, exp, req);
  endtask

  initial begin
    logic [LANE_W-1:0] prev;
    // R6: output cleared while reset is held
    repeat (3) @(negedge clk);
    check(rd_data, 8'h00, "R6 reset clears output");
    rd_rst_n = 1'b1;

    // R1 R2 R3 R8: vector table
    for (int i = 0; i < NV; i++) begin
      if (VECS[i][42])
        do_write(1'b1, VECS[i][39:32], VECS[i][31:0]);
      else
        do_read(VECS[i][41:32], VECS[i][7:0], $sformatf("R1 R2 R3 R8 vector %0d", i));
    end

    // R4: write with strobe low changes nothing
    do_write(1'b0, 8'h00, 32'hffffffff);
    do_read(10'h000, 8'h01, "R4 idle write ignored lane0");
    do_read(10'h002, 8'h45, "R4 idle write ignored lane2");

    // R5: same-edge write and read of one row returns old lane
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'h00; wr_data = 32'h89abcdef; rd_addr = 10'h001;
    @(negedge clk);
    wr_en = 1'b0;
    check(rd_data, 8'h23, "R5 read during write gives old data");
    do_read(10'h001, 8'hab, "R5 new data visible afterwards");
    do_read(10'h000, 8'h89, "R3 new lane0 after rewrite");

    // R7: output holds until the next edge
    @(negedge clk);
    prev = rd_data;
    rd_addr = 10'h003;
    #1;
    check(rd_data, prev, "R7 no change before clock edge");
    @(negedge clk);
    check(rd_data, 8'hef, "R7 new data one cycle later");

    // R6: mid-run reset clears output but keeps contents
    @(negedge clk);
    rd_rst_n = 1'b0;
    @(negedge clk);
    check(rd_data, 8'h00, "R6 mid-run reset clears output");
    rd_rst_n = 1'b1;
    do_read(10'h084, 8'h11, "R6 contents kept across reset");
    do_read(10'h3ff, 8'h0d, "R8 top row untouched");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule